// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit sits beside the integer ALU of a small RISC core and evaluates one operand pair per cycle. It offers a signed ordering compare, an unsigned ordering compare, a first-matching-byte search and a 32-bit add with carry-in. Every accepted operation also produces the carry of `a + b + cin` as a side flag, so a later add-with-carry can consume it without a separate pass.

The compare operations return the difference `b - a`. When the two operand sign bits differ, the top bit of that difference is replaced so that it always reads 1 exactly when `b` orders below `a` in the selected interpretation. Bits below the top keep the raw difference. The byte search scans the byte lanes from the most significant lane downward and reports the first equal lane as a small index.

Operands and the operation code are sampled on a rising clock edge when `in_vld` is high. The result, the carry flag and `res_vld` appear one cycle later, from registers that a synchronous active-low reset clears.

Top module: `cmpx_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res`, `res_vld` and `carry_out` become 0 at that edge.
- R2: `res_vld` is 1 in the cycle after an edge that sampled `in_vld` high and 0 after an edge that sampled it low. Back-to-back inputs give back-to-back results.
- R3: With `op` = 2'b00 (signed compare), `res[30:0]` equals bits 30:0 of `b - a` (modulo 2^32), and `res[31]` is 1 exactly when `b < a` as two's-complement numbers.
- R4: With `op` = 2'b01 (unsigned compare), `res[30:0]` equals bits 30:0 of `b - a`, and `res[31]` is 1 exactly when `b < a` as unsigned numbers.
- R5: With `op` = 2'b10 (byte search), the lanes are compared in the order bits 31:24, 23:16, 15:8, 7:0. `res` is 1, 2, 3 or 4 for the first equal lane in that order, and bits 31:3 are 0.
- R6: With `op` = 2'b10 and no equal lane, `res` is 0.
- R7: With `op` = 2'b11 (add with carry), `res` equals the low 32 bits of `a + b + cin`.
- R8: For every accepted operation, whatever `op` is, `carry_out` equals bit 32 of the 33-bit sum `a + b + cin`, and it is registered in the same cycle as `res`.
- R9: After an edge that sampled `in_vld` low, `res` and `carry_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand pair and code are valid this cycle |
| op | input | 2 | Operation: 00 signed compare, 01 unsigned compare, 10 byte search, 11 add with carry |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b |
| cin | input | 1 | Carry-in for the add and the carry flag |
| res_vld | output | 1 | Result is valid |
| res | output | 32 | Operation result |
| carry_out | output | 1 | Carry of a + b + cin for the accepted pair |

## Verification
The carry flag and the selected operation's result are produced in the same cycle from the same operand pair. Either path could therefore take a stale or wrong operand without the other showing it. The bench provokes this by running each compare and search with `cin` high and operands whose sum overflows, such as 0xFFFFFFFF against 1. It then judges `res` against the operation model and `carry_out` against an independent 33-bit sum in that same result cycle. The corner operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, equal pairs, and matches planted in each byte lane exercise the sign-override and lane-priority paths.

// File: rtl/cmpx_pkg.sv
// Package: shared operation codes for the compare and byte-match unit.
// Assumes a 2-bit operation field driven by the instruction decoder.
package cmpx_pkg;
    typedef enum logic [1:0] {
        OP_SCMP = 2'b00,
        OP_UCMP = 2'b01,
        OP_BFIND = 2'b10,
        OP_ADDC = 2'b11
    } cmpx_op_e;
endpackage

// File: rtl/cmpx_order.sv
// Module: ordering compare. Forms b - a and, when operand signs differ,
// replaces the top bit so that it flags b < a in the chosen interpretation.
// Assumes WIDTH >= 2; purely combinational.
module cmpx_order #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_signed,
    output logic [WIDTH-1:0] diff_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] raw;
    logic             sign_split;

    // Purpose: subtract via inverse-plus-one and patch the order bit.
    always_comb begin
        raw        = b + ~a + {{(WIDTH-1){1'b0}}, 1'b1};
        sign_split = a[MSB] ^ b[MSB];
        diff_out   = raw;
        if (sign_split) begin
            diff_out[MSB] = is_signed ? b[MSB] : a[MSB];
        end
    end
endmodule

// File: rtl/cmpx_bytefind.sv
// Module: first-matching-lane search. Lane 1 is the most significant lane;
// returns its 1-based index for the first equal lane, 0 when none match.
// Assumes WIDTH is a multiple of LANE_W; purely combinational.
module cmpx_bytefind #(
    parameter int WIDTH  = 32,
    parameter int LANE_W = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] pos
);
    localparam int LANES = WIDTH / LANE_W;

    logic [LANES-1:0] hit;

    // One equality comparator per lane, lane 0 at the top of the word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HI = WIDTH - 1 - g * LANE_W;
        assign hit[g] = (a[HI -: LANE_W] == b[HI -: LANE_W]);
    end

    // Purpose: priority pick, lowest lane index (top lane) wins.
    always_comb begin
        pos = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                pos = WIDTH'(k + 1);
            end
        end
    end
endmodule

// File: rtl/cmpx_carry.sv
// Module: add with carry-in and the carry flag of that sum. The flag uses
// the headroom test: carry when b is all ones with cin set, or when the
// room above a is smaller than b + cin. Purely combinational.
module cmpx_carry #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cin_w;
    logic [WIDTH-1:0] b_inc;
    logic [WIDTH-1:0] room;

    // Purpose: form the sum and the headroom-based carry.
    always_comb begin
        cin_w = {{(WIDTH-1){1'b0}}, cin};
        b_inc = b + cin_w;
        room  = ONES - a;
        sum   = a + b_inc;
        cout  = ((b == ONES) && cin) || (room < b_inc);
    end
endmodule

// File: rtl/cmpx_unit.sv
// Module: top of the compare and byte-match unit. Selects one of four
// operations, registers result and carry flag with a valid strobe one cycle
// after the input strobe. Synchronous active-low reset. Holds the last
// result and flag while no input is accepted.
module cmpx_unit #(
    parameter int WIDTH  = 32,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic             res_vld,
    output logic [WIDTH-1:0] res,
    output logic             carry_out
);
    import cmpx_pkg::*;

    cmpx_op_e         op_sel;
    logic [WIDTH-1:0] ord_res;
    logic [WIDTH-1:0] find_res;
    logic [WIDTH-1:0] add_res;
    logic             add_cout;
    logic [WIDTH-1:0] nxt_res;

    assign op_sel = cmpx_op_e'(op);

    cmpx_order #(.WIDTH(WIDTH)) u_order (
        .a         (opa),
        .b         (opb),
        .is_signed (op_sel == OP_SCMP),
        .diff_out  (ord_res)
    );

    cmpx_bytefind #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_find (
        .a   (opa),
        .b   (opb),
        .pos (find_res)
    );

    cmpx_carry #(.WIDTH(WIDTH)) u_carry (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .sum  (add_res),
        .cout (add_cout)
    );

    // Purpose: choose the result for the selected operation.
    always_comb begin
        unique case (op_sel)
            OP_SCMP, OP_UCMP: nxt_res = ord_res;
            OP_BFIND:         nxt_res = find_res;
            default:          nxt_res = add_res;
        endcase
    end

    // Purpose: output registers with synchronous reset and hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            carry_out <= 1'b0;
            res_vld   <= 1'b0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) begin
                res       <= nxt_res;
                carry_out <= add_cout;
            end
        end
    end
endmodule

// File: rtl/cmpx_unit_chk.sv
// Checker: temporal properties of cmpx_unit, attached through bind.
module cmpx_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             res_vld,
    input logic [WIDTH-1:0] res,
    input logic             carry_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (res == '0) && !res_vld && !carry_out); // R1
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld); // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld); // R2
    AST_SCMP_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 2'b00 && opa == opb) |=> (res == '0)); // R3
    AST_UCMP_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 2'b01 && opa == opb) |=> (res == '0)); // R4
    AST_FIND_TOP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 2'b10 && opa[WIDTH-1 -: 8] == opb[WIDTH-1 -: 8])
        |=> (res == WIDTH'(1))); // R5
    AST_FIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 2'b10) |=> (res <= WIDTH'(WIDTH / 8))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res) && $stable(carry_out)); // R9
endmodule

bind cmpx_unit cmpx_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .res_vld   (res_vld),
    .res       (res),
    .carry_out (carry_out)
);

// File: tb/sim_cmpx_unit.sv
// Bench: directed scenarios, one task each, for cmpx_unit.
module sim_cmpx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cin = 1'b0;
    logic        res_vld;
    logic [31:0] res;
    logic        carry_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmpx_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
        .opa(opa), .opb(opb), .cin(cin),
        .res_vld(res_vld), .res(res), .carry_out(carry_out)
    );

    function automatic logic [31:0] model_res(logic [1:0] o, logic [31:0] a,
                                              logic [31:0] b, logic c);
        logic [31:0] d;
        logic [32:0] s;
        d = b - a;
        s = {1'b0, a} + {1'b0, b} + {32'd0, c};
        case (o)
            2'b00: return {($signed(b) < $signed(a)), d[30:0]};
            2'b01: return {(b < a), d[30:0]};
            2'b10: begin
                if (a[31:24] == b[31:24]) return 32'd1;
                else if (a[23:16] == b[23:16]) return 32'd2;
                else if (a[15:8] == b[15:8]) return 32'd3;
                else if (a[7:0] == b[7:0]) return 32'd4;
                else return 32'd0;
            end
            default: return s[31:0];
        endcase
    endfunction

    function automatic logic model_carry(logic [31:0] a, logic [31:0] b, logic c);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b} + {32'd0, c};
        return s[32];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one operation; check result, flag and strobe one cycle later.
    task automatic issue(string req, logic [1:0] o, logic [31:0] a,
                         logic [31:0] b, logic c);
        @(negedge clk);
        in_vld = 1'b1; op = o; opa = a; opb = b; cin = c;
        @(negedge clk);
        chk(req, res, model_res(o, a, b, c));
        chk("R8 carry", {31'd0, carry_out}, {31'd0, model_carry(a, b, c)});
        chk("R2 vld", {31'd0, res_vld}, 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 res", res, 32'd0);
        chk("R1 vld", {31'd0, res_vld}, 32'd0);
        chk("R1 carry", {31'd0, carry_out}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_compare(logic [1:0] o, string req);
        logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                issue(req, o, corner[i], corner[j], 1'b1);
        issue(req, o, 32'h1234_5678, 32'h1234_5678, 1'b0);
    endtask

    task automatic t_find();
        issue("R5 lane1", 2'b10, 32'hAA11_2233, 32'hAA99_8877, 1'b1);
        issue("R5 lane2", 2'b10, 32'h01BB_2233, 32'h02BB_8877, 1'b0);
        issue("R5 lane3", 2'b10, 32'h0102_CC33, 32'h0203_CC77, 1'b1);
        issue("R5 lane4", 2'b10, 32'h0102_03DD, 32'h0203_04DD, 1'b0);
        issue("R5 first wins", 2'b10, 32'h0155_0055, 32'h0255_0355, 1'b0);
        issue("R5 all equal", 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        issue("R6 none", 2'b10, 32'h0102_0304, 32'h1112_1314, 1'b0);
    endtask

    task automatic t_addc();
        issue("R7 wrap", 2'b11, 32'hFFFFFFFF, 32'h0, 1'b1);
        issue("R7 plain", 2'b11, 32'h1, 32'h2, 1'b0);
        issue("R7 max", 2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        issue("R7 signed edge", 2'b11, 32'h7FFFFFFF, 32'h80000000, 1'b1);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        logic        c0;
        issue("R9 setup", 2'b11, 32'hFFFFFFFF, 32'h1, 1'b0);
        r0 = res; c0 = carry_out;
        @(negedge clk);
        in_vld = 1'b0; op = 2'b00; opa = 32'h5; opb = 32'h9; cin = 1'b0;
        @(negedge clk);
        chk("R2 idle vld", {31'd0, res_vld}, 32'd0);
        chk("R9 res held", res, r0);
        chk("R9 carry held", {31'd0, carry_out}, {31'd0, c0});
    endtask

    initial begin
        t_reset();
        t_compare(2'b00, "R3 signed");
        t_compare(2'b01, "R4 unsigned");
        t_find();
        t_addc();
        t_hold();
        t_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule